// File: doc/BRIEF.md
# Memory-Mapped Disk Register Bridge

This block sits between a processor's memory-mapped bus and an ATA-style task-file register interface. Each processor access carries an offset, a direction and a size of byte, halfword or word. The block decides which drive-side register the access reaches, or whether it reaches none. Drive registers sit on a 16-byte stride, so the register index comes from offset bits [11:4].

Byte accesses reach the seven command-block registers and the device-control / alternate-status register. That register answers at two separate indices. Halfword and word accesses reach only the data port. Their data is byte-swapped in both directions, because the processor bus is big-endian and the drive side is little-endian. An access that matches no register does not touch the drive side: a read returns all ones at the access width, and a write is dropped.

The bridge accepts one request per cycle with no stall. It drives a one-cycle read or write strobe on the drive side in the following cycle. In that same cycle it returns a ready pulse and, for reads, the formatted read data. The drive side answers a read combinationally while its read strobe is high.

Top module: `mmio_taskfile_bridge`

## Requirements
- R1: The register index is offset bits [11:4]. Offset bits above bit 11 and below bit 4 have no effect on routing or on data.
- R2: A byte access at index 1 to 7 gives one strobe with `tf_sel` equal to the index and `tf_size` = 00. Write data goes out on `tf_wdata[7:0]`, and a read returns `{24'h0, tf_rdata[7:0]}`.
- R3: A byte access at index 8 or index 22 gives one strobe with `tf_sel` = 8: the control register on a write, alternate status on a read.
- R4: A byte access at any other index, including index 0, gives no strobe. A read there returns 32'h0000_00FF.
- R5: A halfword or word access at an index other than 0 gives no strobe. A read there returns 32'h0000_FFFF for a halfword and 32'hFFFF_FFFF for a word.
- R6: A halfword access at index 0 strobes the data port (`tf_sel` = 0, `tf_size` = 01). The write data is `{16'h0, wdata[7:0], wdata[15:8]}`, and a read returns `{16'h0, tf_rdata[7:0], tf_rdata[15:8]}`.
- R7: A word access at index 0 strobes the data port (`tf_sel` = 0, `tf_size` = 10), with all four bytes reversed in order in both directions.
- R8: Size code 11 is unmapped. It gives no strobe, and a read returns 32'hFFFF_FFFF.
- R9: Each accepted request gives exactly one `rsp_ready` pulse in the next cycle. A mapped access gives exactly one read or write strobe in that same cycle, never both. Back-to-back requests each get their own response.
- R10: While `rst` is high and in the cycle after it, neither strobe nor `rsp_ready` is asserted. `rsp_rdata` is zero whenever no read response is being returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 unmapped |
| req_offset | input | 32 | Access offset; only bits [11:4] are decoded |
| req_wdata | input | 32 | Write data, big-endian lane order |
| rsp_ready | output | 1 | One-cycle response pulse for each accepted request |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` on reads |
| tf_rd | output | 1 | Drive-side read strobe |
| tf_wr | output | 1 | Drive-side write strobe |
| tf_sel | output | 4 | Drive register select: 0 data, 1 to 7 command block, 8 control/alt-status |
| tf_size | output | 2 | Data width of the drive-side access |
| tf_wdata | output | 32 | Drive-side write data, little-endian lane order |
| tf_rdata | input | 32 | Drive-side read data, sampled while `tf_rd` is high |

## Verification
Two functions share each clock cycle. One is the drive-side strobe and read-data formatting for the previous request. The other is the decode and write-lane swap of the next request, which enters in that same cycle. Back-to-back requests with mixed sizes, directions and indices provoke the overlap: valid is held high most of the time. The bench checks that every cycle's strobe, select, write data and returned read data belong to the request issued one cycle earlier. It also checks that none of them leaks into the request that follows.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_NONE = 2'b11
    } acc_size_e;

    localparam logic [3:0] SEL_DATA = 4'd0;
    localparam logic [3:0] SEL_CTRL = 4'd8;

endpackage

// File: rtl/tfb_decode.sv
module tfb_decode
    import tfb_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int CMD_FIRST = 1,
    parameter int CMD_LAST  = 7,
    parameter int CTRL_A    = 8,
    parameter int CTRL_B    = 22
) (
    input  logic             valid,
    input  logic             write,
    input  acc_size_e        size,
    input  logic [IDX_W-1:0] idx,
    output logic             hit,
    output logic [3:0]       sel,
    output logic             rd,
    output logic             wr,
    output logic             miss_rd
);
    localparam logic [IDX_W-1:0] IDX_CMD_LO = IDX_W'(CMD_FIRST);
    localparam logic [IDX_W-1:0] IDX_CMD_HI = IDX_W'(CMD_LAST);
    localparam logic [IDX_W-1:0] IDX_CTL_A  = IDX_W'(CTRL_A);
    localparam logic [IDX_W-1:0] IDX_CTL_B  = IDX_W'(CTRL_B);

    always_comb begin
        hit = 1'b0;
        sel = SEL_DATA;
        unique case (size)
            SZ_BYTE: begin
                if (idx >= IDX_CMD_LO && idx <= IDX_CMD_HI) begin
                    hit = 1'b1;
                    sel = idx[3:0];
                end else if (idx == IDX_CTL_A || idx == IDX_CTL_B) begin
                    hit = 1'b1;
                    sel = SEL_CTRL;
                end
            end
            SZ_HALF, SZ_WORD: begin
                if (idx == '0) begin
                    hit = 1'b1;
                    sel = SEL_DATA;
                end
            end
            default: begin
                hit = 1'b0;
                sel = SEL_DATA;
            end
        endcase
        rd      = valid && hit && !write;
        wr      = valid && hit && write;
        miss_rd = valid && !hit && !write;
    end
endmodule

// File: rtl/tfb_lane_swap.sv
module tfb_lane_swap
    import tfb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] word_rev;
    logic [DATA_W-1:0] half_rev;
    logic [DATA_W-1:0] byte_only;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_rev[8*g +: 8] = din[8*(LANES-1-g) +: 8];
        if (g < 2) begin : g_low
            assign half_rev[8*g +: 8]  = din[8*(1-g) +: 8];
        end else begin : g_high
            assign half_rev[8*g +: 8]  = 8'h00;
        end
        if (g == 0) begin : g_first
            assign byte_only[7:0] = din[7:0];
        end else begin : g_rest
            assign byte_only[8*g +: 8] = 8'h00;
        end
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: dout = byte_only;
            SZ_HALF: dout = half_rev;
            SZ_WORD: dout = word_rev;
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/tfb_resp_fmt.sv
module tfb_resp_fmt
    import tfb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              active,
    input  logic              miss,
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] swapped,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] fill;

    always_comb begin
        unique case (size)
            SZ_BYTE: fill = DATA_W'(8'hFF);
            SZ_HALF: fill = DATA_W'(16'hFFFF);
            default: fill = '1;
        endcase
        if (!active)
            rdata = '0;
        else if (miss)
            rdata = fill;
        else
            rdata = swapped;
    end
endmodule

// File: rtl/mmio_taskfile_bridge.sv
module mmio_taskfile_bridge
    import tfb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int IDX_LSB = 4,
    parameter int IDX_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              tf_rd,
    output logic              tf_wr,
    output logic [3:0]        tf_sel,
    output logic [1:0]        tf_size,
    output logic [DATA_W-1:0] tf_wdata,
    input  logic [DATA_W-1:0] tf_rdata
);
    typedef struct packed {
        logic              ready;
        logic              is_read;
        logic              rd;
        logic              wr;
        logic              miss;
        logic [3:0]        sel;
        acc_size_e         size;
        logic [DATA_W-1:0] wdata;
    } stage_t;

    stage_t st_d, st_q;

    acc_size_e         size_in;
    logic [IDX_W-1:0]  idx_in;
    logic              dec_hit, dec_rd, dec_wr, dec_miss_rd;
    logic [3:0]        dec_sel;
    logic [DATA_W-1:0] wdata_sw;
    logic [DATA_W-1:0] rdata_sw;

    assign size_in = acc_size_e'(req_size);
    assign idx_in  = req_offset[IDX_LSB +: IDX_W];

    tfb_decode #(.IDX_W(IDX_W)) u_decode (
        .valid   (req_valid),
        .write   (req_write),
        .size    (size_in),
        .idx     (idx_in),
        .hit     (dec_hit),
        .sel     (dec_sel),
        .rd      (dec_rd),
        .wr      (dec_wr),
        .miss_rd (dec_miss_rd)
    );

    tfb_lane_swap #(.DATA_W(DATA_W)) u_wswap (
        .size (size_in),
        .din  (req_wdata),
        .dout (wdata_sw)
    );

    always_comb begin
        st_d         = '0;
        st_d.ready   = req_valid;
        st_d.is_read = req_valid && !req_write;
        st_d.rd      = dec_rd;
        st_d.wr      = dec_wr;
        st_d.miss    = dec_miss_rd;
        st_d.sel     = dec_hit ? dec_sel : SEL_DATA;
        st_d.size    = size_in;
        st_d.wdata   = dec_wr ? wdata_sw : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    tfb_lane_swap #(.DATA_W(DATA_W)) u_rswap (
        .size (st_q.size),
        .din  (tf_rdata),
        .dout (rdata_sw)
    );

    tfb_resp_fmt #(.DATA_W(DATA_W)) u_fmt (
        .active  (st_q.is_read),
        .miss    (st_q.miss),
        .size    (st_q.size),
        .swapped (rdata_sw),
        .rdata   (rsp_rdata)
    );

    assign rsp_ready = st_q.ready;
    assign tf_rd     = st_q.rd;
    assign tf_wr     = st_q.wr;
    assign tf_sel    = st_q.sel;
    assign tf_size   = st_q.size;
    assign tf_wdata  = st_q.wdata;
endmodule

// File: rtl/tfb_checker.sv
module tfb_checker #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int IDX_LSB = 4,
    parameter int IDX_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_offset,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              tf_rd,
    input logic              tf_wr,
    input logic [3:0]        tf_sel
);
    logic [IDX_W-1:0] ix;
    logic             byte_unmapped;
    assign ix = req_offset[IDX_LSB +: IDX_W];
    assign byte_unmapped = !((ix >= IDX_W'(1) && ix <= IDX_W'(8)) || ix == IDX_W'(22));

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !(tf_rd && tf_wr));

    assert_resp_follows_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_ready);

    assert_resp_has_req_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |-> $past(req_valid));

    assert_strobe_with_resp_R9: assert property (@(posedge clk) disable iff (rst)
        (tf_rd || tf_wr) |-> rsp_ready);

    assert_alias_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'b00 && ix == IDX_W'(22))
        |=> ((tf_rd || tf_wr) && tf_sel == 4'd8));

    assert_byte_hole_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'b00 && byte_unmapped)
        |=> (!tf_rd && !tf_wr));

    assert_wide_hole_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_size == 2'b01 || req_size == 2'b10) && ix != '0)
        |=> (!tf_rd && !tf_wr));

    assert_half_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 2'b01 && ix != '0)
        |=> rsp_rdata == DATA_W'(16'hFFFF));

    assert_bad_size_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 2'b11)
        |=> (!tf_rd && rsp_rdata == '1));

    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
        !rsp_ready |-> rsp_rdata == '0);
endmodule

bind mmio_taskfile_bridge tfb_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .tf_rd(tf_rd),
    .tf_wr(tf_wr), .tf_sel(tf_sel)
);

// File: tb/mmio_taskfile_bridge_tb.sv
module mmio_taskfile_bridge_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [1:0]  req_size;
    logic [31:0] req_offset, req_wdata;
    logic        rsp_ready, tf_rd, tf_wr;
    logic [31:0] rsp_rdata, tf_wdata, tf_rdata;
    logic [3:0]  tf_sel;
    logic [1:0]  tf_size;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    mmio_taskfile_bridge u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_offset(req_offset), .req_wdata(req_wdata),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .tf_rd(tf_rd),
        .tf_wr(tf_wr), .tf_sel(tf_sel), .tf_size(tf_size),
        .tf_wdata(tf_wdata), .tf_rdata(tf_rdata)
    );

    // drive-side model: a distinct pattern per register select
    function automatic logic [31:0] drive_val(input logic [3:0] s);
        return {8'hC3, 4'h5, s, 8'h96, 4'h4, ~s};
    endfunction
    assign tf_rdata = tf_rd ? drive_val(tf_sel) : 32'hDEAD_BEEF;

    // expected routing: returns 1 when mapped, sel through ref
    function automatic bit exp_map(input logic [1:0] sz, input logic [31:0] off,
                                   output logic [3:0] s);
        int ix = int'(off[11:4]);
        s = 4'd0;
        if (sz == 2'b00) begin
            if (ix >= 1 && ix <= 7) begin s = 4'(ix); return 1; end
            if (ix == 8 || ix == 22) begin s = 4'd8; return 1; end
            return 0;
        end
        if (sz == 2'b01 || sz == 2'b10) return (ix == 0);
        return 0;
    endfunction

    function automatic logic [31:0] exp_lanes(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'b00:   return {24'h0, d[7:0]};
            2'b01:   return {16'h0, d[7:0], d[15:8]};
            2'b10:   return {d[7:0], d[15:8], d[23:16], d[31:24]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] sz, input logic [31:0] off);
        logic [3:0] s;
        bit m = exp_map(sz, off, s);
        if (sz == 2'b11) return "R8";
        if (sz == 2'b00) return m ? ((s == 4'd8) ? "R3" : "R2") : "R4";
        if (!m) return "R5";
        return (sz == 2'b01) ? "R6" : "R7";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // previous request, checked one cycle after it was driven
    bit          p_v;
    logic        p_w;
    logic [1:0]  p_sz;
    logic [31:0] p_off, p_wd;

    task automatic check_prev();
        logic [3:0] s;
        bit m;
        string t;
        logic [31:0] er;
        if (!p_v) begin
            check("R9", "idle ready", {31'h0, rsp_ready}, 32'h0);
            check("R10", "idle rdata", rsp_rdata, 32'h0);
            check("R9", "idle strobes", {30'h0, tf_rd, tf_wr}, 32'h0);
            return;
        end
        m = exp_map(p_sz, p_off, s);
        t = tag_of(p_sz, p_off);
        check("R9", "ready", {31'h0, rsp_ready}, 32'h1);
        check(t, "rd strobe", {31'h0, tf_rd}, {31'h0, m && !p_w});
        check(t, "wr strobe", {31'h0, tf_wr}, {31'h0, m && p_w});
        if (m) begin
            check(t, "sel", {28'h0, tf_sel}, {28'h0, s});
            check(t, "size", {30'h0, tf_size}, {30'h0, p_sz});
        end
        if (m && p_w) check(t, "wdata", tf_wdata, exp_lanes(p_sz, p_wd));
        if (!p_w) begin
            if (m) er = exp_lanes(p_sz, drive_val(s));
            else if (p_sz == 2'b00) er = 32'h0000_00FF;
            else if (p_sz == 2'b01) er = 32'h0000_FFFF;
            else er = 32'hFFFF_FFFF;
            check(t, "rdata", rsp_rdata, er);
        end else begin
            check("R10", "rdata on write", rsp_rdata, 32'h0);
        end
    endtask

    task automatic step(input bit v, input bit w, input logic [1:0] sz,
                        input logic [31:0] off, input logic [31:0] wd);
        @(negedge clk);
        check_prev();
        req_valid = v; req_write = w; req_size = sz; req_offset = off; req_wdata = wd;
        p_v = v; p_w = w; p_sz = sz; p_off = off; p_wd = wd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5EED_0042;
        void'($urandom(seed));
        rst = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'b00;
        req_offset = 32'h0000_0010; req_wdata = 32'h55;
        p_v = 0; p_w = 0; p_sz = 0; p_off = 0; p_wd = 0;
        @(posedge clk);
        // R10: strobes and ready stay low during reset despite a live request
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R10", "reset strobes", {30'h0, tf_rd, tf_wr}, 32'h0);
            check("R10", "reset ready", {31'h0, rsp_ready}, 32'h0);
            check("R10", "reset rdata", rsp_rdata, 32'h0);
        end
        rst = 1'b0;
        req_valid = 1'b0;
        // directed corner cases
        step(1, 0, 2'b00, 32'hFFFF_F03C, 0);            // R1 junk bits, cmd 3
        step(1, 1, 2'b00, 32'h0000_0160, 32'hAB);       // R3 alias 22 write
        step(1, 0, 2'b00, 32'h0000_008F, 0);            // R3 index 8 read
        step(1, 0, 2'b00, 32'h0000_0000, 0);            // R4 byte at data index
        step(1, 1, 2'b00, 32'h0000_0090, 32'h77);       // R4 index 9 write dropped
        step(1, 1, 2'b01, 32'h0000_1000, 32'hFFFF_1234);// R1/R6 half write
        step(1, 0, 2'b01, 32'hABC0_000E, 0);            // R1/R6 half read
        step(1, 1, 2'b10, 32'h0000_0000, 32'h0102_0304);// R7 word write
        step(1, 0, 2'b10, 32'h0000_0000, 0);            // R7 word read
        step(1, 0, 2'b01, 32'h0000_0010, 0);            // R5 half miss
        step(1, 0, 2'b10, 32'h0000_0010, 0);            // R5 word miss
        step(1, 0, 2'b11, 32'h0000_0000, 0);            // R8 bad size read
        step(1, 1, 2'b11, 32'h0000_0000, 32'hFFFF_FFFF);// R8 bad size write
        step(0, 0, 2'b00, 0, 0);
        step(1, 0, 2'b00, 32'h0000_0070, 0);            // R2 cmd 7
        // R9: random back-to-back traffic
        for (int n = 0; n < 4000; n++) begin
            int pick = $urandom_range(0, 15);
            logic [31:0] off = $urandom();
            if (pick < 12) off[11:4] = (pick == 11) ? 8'd22 : 8'(pick);
            step(($urandom_range(0, 9) < 8), $urandom_range(0, 1),
                 2'($urandom_range(0, 3)), off, $urandom());
        end
        step(0, 0, 2'b00, 0, 0);
        step(0, 0, 2'b00, 0, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule